// File: doc/BRIEF.md
# Edge-List Digital Timing Generator

This block drives a group of digital output lines from a short list of timed edge events instead of from one stored word per clock. Each list entry carries a delay, counted in master ticks from the previous event, together with a change mask and a level field. Only the lines selected by the mask move, and they move to the given levels. A tick counter runs between events. When it reaches the delay of the pending entry, the entry is applied and the following entry is fetched from the list store.

The list is replayed a chosen number of times, or without end. The host loads entries through a simple write port into a shadow copy of the list. That copy becomes the working list when a run starts, and again at each pass boundary, so a pattern can be reshaped while output continues and no entry is ever seen half written. Fetching an entry takes time. If an entry's delay is shorter than that fetch time, it is already late when it becomes ready. In that case a sticky flag is raised and the entry is applied on the next tick.

Top module: `edge_timing_gen`

## Requirements
- R1: After reset, `dout` is all zeros and both `busy` and `underrun` are low.
- R2: A list entry is the word {last[45], level[44:37], mask[36:29], delay[28:0]}. After a run start, or after an entry is applied, the next entry is applied on the clock edge that carries the delay-th asserted `tick` counted from that point. The tick sampled on the reference edge itself is not counted.
- R3: Applying an entry sets each `dout` bit whose mask bit is 1 to the matching level bit. Bits whose mask bit is 0 keep their value.
- R4: A `start` pulse while idle begins a run, and `busy` goes high after that edge. With `loop_count` N greater than 0, the list (entries from address 0 up to the first one with its last bit set, or up to the top address) is played N times. `busy` drops on the edge that applies the final entry of the last pass, and `dout` holds while idle.
- R5: A `loop_count` of 0 replays the list without end, and `busy` stays high.
- R6: Delays count only clock cycles with `tick` high. `dout` never changes on an edge where `tick` is low.
- R7: Writes land in a shadow list. The working list is replaced by the shadow list only at a run start or when a pass wraps back to address 0. A write made during a pass has no effect on that pass.
- R8: If an entry's due tick has already passed when it becomes ready, `underrun` is set and the entry is applied on the next tick. With `tick` high on every cycle, this happens for any delay below 2. `underrun` stays set until the next accepted `start`, which clears it.
- R9: `start` is ignored while `busy` is high. The timing of the run in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Master time-base enable, one tick per high cycle |
| start | input | 1 | Begin a run when idle |
| loop_count | input | 16 | Number of passes, 0 = endless, sampled at start |
| wr_en | input | 1 | Write one entry into the shadow list |
| wr_addr | input | 4 | Shadow list address |
| wr_data | input | 46 | Entry word {last, level, mask, delay} |
| dout | output | 8 | Generated timing lines |
| busy | output | 1 | A run is in progress |
| underrun | output | 1 | Sticky: an entry was applied late |

## Verification
The checker watches four rules on every cycle. The lines stay still on any edge without a tick. The lines are frozen while idle. An accepted start always raises `busy`. A set underrun flag only clears through an accepted start. The scenarios are the only way to show that each edge lands on exactly the right tick, that masked bits are preserved, and that the pass count and the endless mode are honoured. They also show that a mid-pass rewrite stays invisible until the wrap, that a late entry is flagged and applied one tick later, and that a second start during a run leaves the edge timing untouched.

// File: rtl/edge_gen_pkg.sv
// Shared types for the edge-list timing generator.
// Assumes: a sequencer that cycles idle -> fetch -> wait -> fetch ...
package edge_gen_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/edge_store.sv
// Edge list storage: a host-written shadow copy and a working copy.
// The working copy is replaced wholesale by the shadow on a swap pulse.
// Reads are registered: the entry at rd_addr appears one cycle later.
// Assumes: swap is a single-cycle pulse; writes may coincide with swap
// (the write lands in the shadow, and the swap copies the old shadow).
module edge_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 46,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic               swap,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    logic [ENTRY_W-1:0] shadow_q [DEPTH];
    logic [ENTRY_W-1:0] active_q [DEPTH];

    // Host writes go into the shadow list only.
    always_ff @(posedge clk) begin
        if (wr_en) shadow_q[wr_addr] <= wr_data;
    end

    // Whole-list copy so a pass never sees a half-updated entry.
    always_ff @(posedge clk) begin
        if (swap) active_q <= shadow_q;
    end

    // Registered read port of the working list.
    always_ff @(posedge clk) begin
        rd_data <= active_q[rd_addr];
    end

endmodule

// File: rtl/edge_timer.sv
// Tick counter between edge events.
// Counts asserted ticks since the last clear and compares against the
// pending delay. due: this tick reaches or passes the delay.
// late: this tick is beyond the delay.
// Assumes: clear has priority over counting; the counter saturates.
module edge_timer #(
    parameter int TIME_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              clear,
    input  logic [TIME_W-1:0] delay,
    output logic              due,
    output logic              late
);

    logic [TIME_W-1:0] cnt_q;
    logic [TIME_W:0]   cnt_nx;

    assign cnt_nx = {1'b0, cnt_q} + 1'b1;

    // Count ticks since the reference edge, saturating at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                       cnt_q <= '0;
        else if (tick && (cnt_q != {TIME_W{1'b1}})) cnt_q <= cnt_nx[TIME_W-1:0];
    end

    // Compare the tick being taken now against the delay.
    always_comb begin
        due  = tick && (cnt_nx >= {1'b0, delay});
        late = tick && (cnt_nx >  {1'b0, delay});
    end

endmodule

// File: rtl/edge_sequencer.sv
// Walks the edge list: fetch an entry, wait for its tick, apply it to
// the outputs, then advance or wrap, counting passes.
// Assumes: the store read is one cycle of latency (one FETCH cycle).
// An entry is the last one if its last bit is set or it is at the top
// address.
module edge_sequencer
    import edge_gen_pkg::*;
#(
    parameter int NUM_OUT = 8,
    parameter int TIME_W  = 29,
    parameter int DEPTH   = 16,
    parameter int LOOP_W  = 16,
    localparam int AW      = $clog2(DEPTH),
    localparam int ENTRY_W = 1 + 2 * NUM_OUT + TIME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LOOP_W-1:0]  loop_count,
    input  logic [ENTRY_W-1:0] entry,
    input  logic               due,
    input  logic               late,
    output logic [TIME_W-1:0]  delay,
    output logic [AW-1:0]      ptr,
    output logic               swap,
    output logic               timer_clear,
    output logic [NUM_OUT-1:0] dout,
    output logic               busy,
    output logic               underrun
);

    localparam int MASK_LO = TIME_W;
    localparam int LVL_LO  = TIME_W + NUM_OUT;
    localparam int LAST_B  = ENTRY_W - 1;

    seq_state_t         state_q;
    logic [LOOP_W-1:0]  loops_q;
    logic               endless_q;
    logic [NUM_OUT-1:0] mask, level;
    logic               is_last, accept, apply, again;

    // Split the fetched entry into its fields.
    always_comb begin
        delay   = entry[TIME_W-1:0];
        mask    = entry[MASK_LO +: NUM_OUT];
        level   = entry[LVL_LO +: NUM_OUT];
        is_last = entry[LAST_B] || (ptr == AW'(DEPTH - 1));
    end

    // Event decisions for this cycle.
    always_comb begin
        accept      = (state_q == SEQ_IDLE) && start;
        apply       = (state_q == SEQ_WAIT) && due;
        again       = endless_q || (loops_q > LOOP_W'(1));
        swap        = accept || (apply && is_last && again);
        timer_clear = accept || apply;
        busy        = (state_q != SEQ_IDLE);
    end

    // Sequencer state, list pointer and pass counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            ptr       <= '0;
            loops_q   <= '0;
            endless_q <= 1'b0;
        end else if (accept) begin
            state_q   <= SEQ_FETCH;
            ptr       <= '0;
            loops_q   <= loop_count;
            endless_q <= (loop_count == '0);
        end else if (state_q == SEQ_FETCH) begin
            state_q <= SEQ_WAIT;
        end else if (apply) begin
            if (!is_last) begin
                ptr     <= ptr + 1'b1;
                state_q <= SEQ_FETCH;
            end else if (again) begin
                ptr     <= '0;
                state_q <= SEQ_FETCH;
                if (!endless_q) loops_q <= loops_q - 1'b1;
            end else begin
                state_q <= SEQ_IDLE;
            end
        end
    end

    // Output lines: masked bits take the entry's levels.
    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (apply) dout <= (dout & ~mask) | (level & mask);
    end

    // Sticky late-entry flag, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || accept)  underrun <= 1'b0;
        else if (apply && late) underrun <= 1'b1;
    end

endmodule

// File: rtl/edge_timing_gen.sv
// Top of the edge-list timing generator: list store, tick timer and
// sequencer. The host writes entries through wr_*; start runs the list
// loop_count times (0 = endless).
// Assumes: tick is a clock-enable from the master time base.
module edge_timing_gen #(
    parameter int NUM_OUT = 8,
    parameter int TIME_W  = 29,
    parameter int DEPTH   = 16,
    parameter int LOOP_W  = 16,
    localparam int AW      = $clog2(DEPTH),
    localparam int ENTRY_W = 1 + 2 * NUM_OUT + TIME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               start,
    input  logic [LOOP_W-1:0]  loop_count,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic [NUM_OUT-1:0] dout,
    output logic               busy,
    output logic               underrun
);

    logic [ENTRY_W-1:0] rd_entry;
    logic [AW-1:0]      rd_ptr;
    logic [TIME_W-1:0]  cur_delay;
    logic               swap, tclear, due, late;

    edge_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .swap    (swap),
        .rd_addr (rd_ptr),
        .rd_data (rd_entry)
    );

    edge_timer #(.TIME_W(TIME_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .clear (tclear),
        .delay (cur_delay),
        .due   (due),
        .late  (late)
    );

    edge_sequencer #(
        .NUM_OUT (NUM_OUT),
        .TIME_W  (TIME_W),
        .DEPTH   (DEPTH),
        .LOOP_W  (LOOP_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .loop_count  (loop_count),
        .entry       (rd_entry),
        .due         (due),
        .late        (late),
        .delay       (cur_delay),
        .ptr         (rd_ptr),
        .swap        (swap),
        .timer_clear (tclear),
        .dout        (dout),
        .busy        (busy),
        .underrun    (underrun)
    );

endmodule

// File: rtl/edge_timing_gen_chk.sv
// Cycle-by-cycle rules for the edge-list timing generator, bound to
// the top module.
module edge_timing_gen_chk #(
    parameter int NUM_OUT = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               start,
    input logic [NUM_OUT-1:0] dout,
    input logic               busy,
    input logic               underrun
);

    AST_NO_EDGE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dout)) else $error("dout moved without tick"); // R6

    AST_IDLE_HOLDS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(dout)) else $error("dout moved while idle"); // R4

    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy) else $error("start not accepted"); // R4

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !(start && !busy)) |=> underrun) else $error("underrun lost"); // R8

endmodule

bind edge_timing_gen edge_timing_gen_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .start    (start),
    .dout     (dout),
    .busy     (busy),
    .underrun (underrun)
);

// File: tb/sim_edge_timing_gen.sv
// Directed bench for edge_timing_gen: one task per scenario.
module sim_edge_timing_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b1;
    logic        start = 1'b0;
    logic [15:0] loop_count = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [45:0] wr_data = '0;
    logic [7:0]  dout;
    logic        busy;
    logic        underrun;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edge_timing_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .start      (start),
        .loop_count (loop_count),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .dout       (dout),
        .busy       (busy),
        .underrun   (underrun)
    );

    // Advance n edges, then settle just after the last one.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one shadow write for the next edge (caller advances).
    task automatic drive_wr(input int a, input int dly, input logic [7:0] m,
                            input logic [7:0] l, input logic last);
        wr_en   = 1'b1;
        wr_addr = 4'(a);
        wr_data = {last, l, m, 29'(dly)};
    endtask

    task automatic wr(input int a, input int dly, input logic [7:0] m,
                      input logic [7:0] l, input logic last);
        drive_wr(a, dly, m, l, last);
        step(1);
        wr_en = 1'b0;
    endtask

    // Pulse start; returns just after the accepting edge E0.
    task automatic start_run(input int loops);
        start      = 1'b1;
        loop_count = 16'(loops);
        step(1);
        start = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 dout", 32'(dout), 32'h00);
        check("R1 busy", 32'(busy), 0);
        check("R1 underrun", 32'(underrun), 0);
    endtask

    task automatic t_single_pass();
        wr(0, 3, 8'hFF, 8'h0F, 1'b0);
        wr(1, 5, 8'hF0, 8'hF0, 1'b0);
        wr(2, 4, 8'hFF, 8'h00, 1'b1);
        start_run(1);                       // E0
        check("R4 busy after start", 32'(busy), 1);
        step(2);                            // E0+2
        check("R2 not early", 32'(dout), 32'h00);
        step(1);                            // E0+3
        check("R2 first edge", 32'(dout), 32'h0F);
        start = 1'b1;                       // R9: pulse start at E0+4
        step(1);
        start = 1'b0;
        step(3);                            // E0+7
        check("R9 timing held", 32'(dout), 32'h0F);
        step(1);                            // E0+8
        check("R3 mask keeps low nibble", 32'(dout), 32'hFF);
        step(4);                            // E0+12
        check("R2 last edge", 32'(dout), 32'h00);
        check("R4 busy drops", 32'(busy), 0);
        check("R8 no underrun", 32'(underrun), 0);
    endtask

    task automatic t_two_passes();
        wr(0, 2, 8'h01, 8'h01, 1'b0);
        wr(1, 3, 8'h01, 8'h00, 1'b1);
        start_run(2);                       // E0
        step(2);  check("R4 pass1 rise", 32'(dout), 32'h01);
        step(3);  check("R4 pass1 fall", 32'(dout), 32'h00);
        check("R4 busy between passes", 32'(busy), 1);
        step(2);  check("R4 pass2 rise", 32'(dout), 32'h01);
        step(3);  check("R4 pass2 fall", 32'(dout), 32'h00);
        check("R4 done after 2", 32'(busy), 0);
        step(4);  check("R4 idle hold", 32'(dout), 32'h00);
    endtask

    task automatic t_endless_shadow();
        wr(0, 2, 8'h02, 8'h02, 1'b0);
        wr(1, 2, 8'h02, 8'h00, 1'b1);
        start_run(0);                       // E0
        step(1);                            // E0+1
        drive_wr(0, 2, 8'h04, 8'h04, 1'b0);
        step(1);                            // E0+2
        check("R5 first rise", 32'(dout), 32'h02);
        drive_wr(1, 2, 8'h06, 8'h02, 1'b1);
        step(1);                            // E0+3
        wr_en = 1'b0;
        step(1);                            // E0+4
        check("R7 old entry this pass", 32'(dout), 32'h00);
        step(2);                            // E0+6
        check("R7 new list after wrap", 32'(dout), 32'h04);
        step(2);                            // E0+8
        check("R7 new last entry", 32'(dout), 32'h02);
        step(2);                            // E0+10
        check("R5 still running", 32'(dout), 32'h06);
        check("R5 busy endless", 32'(busy), 1);
        do_reset();
    endtask

    task automatic t_underrun();
        wr(0, 1, 8'hFF, 8'hAA, 1'b0);
        wr(1, 3, 8'hFF, 8'h55, 1'b1);
        start_run(1);                       // E0
        step(1);                            // E0+1
        check("R8 not yet applied", 32'(dout), 32'h00);
        check("R8 flag clear", 32'(underrun), 0);
        step(1);                            // E0+2
        check("R8 late apply", 32'(dout), 32'hAA);
        check("R8 flag set", 32'(underrun), 1);
        step(3);                            // E0+5
        check("R8 next entry", 32'(dout), 32'h55);
        check("R8 sticky", 32'(underrun), 1);
        wr(0, 2, 8'hFF, 8'hAA, 1'b0);
        start_run(1);
        step(1);
        check("R8 cleared by start", 32'(underrun), 0);
        step(4);
        check("R8 clean run", 32'(dout), 32'h55);
        check("R8 stays clear", 32'(underrun), 0);
    endtask

    task automatic t_sparse_tick();
        wr(0, 3, 8'h80, 8'h80, 1'b1);
        tick = 1'b0;
        start_run(1);                       // E0, no tick
        for (int k = 1; k <= 3; k++) begin
            step(3);
            if (k == 3) check("R6 no edge before tick", 32'(dout), 32'h55);
            tick = 1'b1;
            step(1);
            tick = 1'b0;
            if (k == 2) check("R6 two ticks only", 32'(dout), 32'h55);
        end
        check("R6 edge on third tick", 32'(dout), 32'hD5);
        check("R6 done", 32'(busy), 0);
        tick = 1'b1;
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_single_pass();
        t_two_passes();
        t_endless_shadow();
        t_reset();
        t_underrun();
        t_sparse_tick();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule